// File: doc/BRIEF.md
# Ordered Store Queue with Byte Forwarding

This block holds the stores issued by one in-order core until the cache can take them. Each store is accepted in one cycle and later written to the cache in the exact order it arrived. A load does not wait for those stores. It reads the cache at once. Any byte that a still-queued store covers is taken from the queue instead of the cache. When several queued stores cover the same byte, the youngest one wins. A load that only partly overlaps the queued stores gets a word that mixes queued bytes with cache bytes.

Two request kinds act as full barriers: a word swap and a fence. Both stall until the queue is empty. The swap then reads the old word and writes the new word to the cache in the same cycle, as one indivisible step, and returns the old word. The fence simply returns an acknowledge once the queue has drained. The request port applies backpressure. Stores stall while the queue is full. Swaps and fences stall until the queue is empty.

Top module: `tso_store_buf`

## Requirements
- R1: After reset the queue is empty. `cw_valid` and `rsp_valid` are low, and a store request sees `req_ready` high.
- R2: Queued stores reach the cache write port in the order they were accepted. The head entry is removed only in a cycle where `cw_ready` is high. While `cw_ready` is low, the address and data on the write port stay unchanged.
- R3: The queue holds DEPTH (default 8) stores. When it is full, a store request sees `req_ready` low. One dequeue makes room again.
- R4: `req_op` encoding: 0 = load, 1 = store, 2 = swap, 3 = fence. Each accepted load, swap or fence gives exactly one `rsp_valid` pulse, in the cycle after acceptance. Stores give none.
- R5: A load returns each byte from the youngest queued store whose word address matches and whose byte enable covers that byte. The choice is made separately for every byte. Byte b is `data[8b+7:8b]`, enabled by `be[b]`.
- R6: A load byte that no queued store covers comes from the cache word read at the load address. A partly overlapping load therefore returns a merged word.
- R7: A swap is not accepted until the queue is empty. It then writes the full new word (all byte enables set) to the cache and returns the old cache word.
- R8: A fence is not accepted while any store is queued. Once the queue is empty it is accepted, and its response carries data 0.
- R9: A load is accepted in the cycle it is presented, even when stores are queued and even when the queue is full.
- R10: A store can be accepted in the same cycle that the head entry is written out. Continuous streaming loses no store and does not reorder any store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Request kind: 0 load, 1 store, 2 swap, 3 fence |
| req_addr | input | 32 | Byte address; the low two bits are ignored |
| req_wdata | input | 32 | Store or swap data |
| req_be | input | 4 | Store byte enables |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| rsp_valid | output | 1 | Registered response strobe for load, swap and fence |
| rsp_data | output | 32 | Load data, old swap word, or 0 for a fence |
| cw_valid | output | 1 | Cache write request |
| cw_addr | output | 32 | Cache write word address |
| cw_data | output | 32 | Cache write data |
| cw_be | output | 4 | Cache write byte enables |
| cw_ready | input | 1 | Cache accepts the write this cycle |
| cr_en | output | 1 | Cache read strobe for load or swap |
| cr_addr | output | 32 | Cache read word address |
| cr_data | input | 32 | Cache read data, valid in the same cycle as cr_addr |

## Verification
The assertions assume that the cache read port answers in the same cycle and that `cr_data` is the word as it stood before any write at the coming edge. They also assume the request fields are held steady while `req_valid` waits for `req_ready`. The bench provides this with a combinational memory model that updates on the clock edge with nonblocking writes. It changes request fields only at falling edges and keeps them in place until acceptance. The bench toggles `cw_ready` on its own schedule, so stall, drain and streaming all occur.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;
  localparam int OFS_W   = $clog2(BE_W);
  localparam int WADDR_W = ADDR_W - OFS_W;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_SWAP  = 2'd2,
    OP_FENCE = 2'd3
  } mem_op_e;

  typedef struct packed {
    logic [WADDR_W-1:0] waddr;
    logic [DATA_W-1:0]  data;
    logic [BE_W-1:0]    be;
  } sb_entry_t;
endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  sb_entry_t         push_ent,
  input  logic              pop,
  output sb_entry_t         head_ent,
  output logic              full,
  output logic              empty,
  output sb_entry_t         ord_ent [DEPTH],
  output logic [DEPTH-1:0]  ord_vld
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  sb_entry_t        slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign head_ent = slots[rd_ptr];

  // age-ordered view: index 0 is the oldest entry
  always_comb begin
    logic [PTR_W:0] s;
    for (int i = 0; i < DEPTH; i++) begin
      s = {1'b0, rd_ptr} + (PTR_W+1)'(i);
      if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
      ord_ent[i] = slots[s[PTR_W-1:0]];
      ord_vld[i] = (CNT_W'(i) < count);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  a_r10_count_track: assert property (@(posedge clk) disable iff (rst)
    (push || pop) |=> count == $past(count) + CNT_W'($past(push)) - CNT_W'($past(pop)));
endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  sb_entry_t          ord_ent [DEPTH],
  input  logic [DEPTH-1:0]   ord_vld,
  input  logic [WADDR_W-1:0] ld_waddr,
  input  logic [DATA_W-1:0]  cache_word,
  output logic [DATA_W-1:0]  merged
);
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    logic [7:0] lane;
    always_comb begin
      lane = cache_word[b*8 +: 8];
      // later (younger) matches override earlier ones
      for (int i = 0; i < DEPTH; i++) begin
        if (ord_vld[i] && ord_ent[i].be[b] && (ord_ent[i].waddr == ld_waddr))
          lane = ord_ent[i].data[b*8 +: 8];
      end
    end
    assign merged[b*8 +: 8] = lane;
  end
endmodule

// File: rtl/tso_store_buf.sv
module tso_store_buf
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              cw_valid,
  output logic [ADDR_W-1:0] cw_addr,
  output logic [DATA_W-1:0] cw_data,
  output logic [BE_W-1:0]   cw_be,
  input  logic              cw_ready,
  output logic              cr_en,
  output logic [ADDR_W-1:0] cr_addr,
  input  logic [DATA_W-1:0] cr_data
);
  mem_op_e            op;
  logic               acc, push, pop, full, empty, swap_go;
  sb_entry_t          head_ent, new_ent;
  sb_entry_t          ord_ent [DEPTH];
  logic [DEPTH-1:0]   ord_vld;
  logic [WADDR_W-1:0] req_waddr;
  logic [DATA_W-1:0]  fwd_word;

  assign op        = mem_op_e'(req_op);
  assign req_waddr = req_addr[ADDR_W-1:OFS_W];

  always_comb begin
    unique case (op)
      OP_LOAD:  req_ready = 1'b1;
      OP_STORE: req_ready = !full;
      OP_SWAP:  req_ready = empty && cw_ready;
      default:  req_ready = empty;
    endcase
  end

  assign acc     = req_valid && req_ready;
  assign push    = acc && (op == OP_STORE);
  assign pop     = !empty && cw_ready;
  assign swap_go = empty && req_valid && (op == OP_SWAP);
  assign new_ent = '{waddr: req_waddr, data: req_wdata, be: req_be};

  sbuf_queue #(.DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_ent (new_ent),
    .pop      (pop),
    .head_ent (head_ent),
    .full     (full),
    .empty    (empty),
    .ord_ent  (ord_ent),
    .ord_vld  (ord_vld)
  );

  sbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
    .ord_ent    (ord_ent),
    .ord_vld    (ord_vld),
    .ld_waddr   (req_waddr),
    .cache_word (cr_data),
    .merged     (fwd_word)
  );

  // write port: queue head, or the swap's write once the queue is empty
  always_comb begin
    if (!empty) begin
      cw_valid = 1'b1;
      cw_addr  = {head_ent.waddr, {OFS_W{1'b0}}};
      cw_data  = head_ent.data;
      cw_be    = head_ent.be;
    end else begin
      cw_valid = swap_go;
      cw_addr  = {req_waddr, {OFS_W{1'b0}}};
      cw_data  = req_wdata;
      cw_be    = {BE_W{1'b1}};
    end
  end

  assign cr_en   = req_valid && ((op == OP_LOAD) || (op == OP_SWAP));
  assign cr_addr = {req_waddr, {OFS_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc && (op != OP_STORE);
      if (acc) begin
        unique case (op)
          OP_LOAD:  rsp_data <= fwd_word;
          OP_SWAP:  rsp_data <= cr_data;
          OP_FENCE: rsp_data <= '0;
          default:  rsp_data <= rsp_data;
        endcase
      end
    end
  end

  a_r4_one_rsp: assert property (@(posedge clk) disable iff (rst)
    (acc && op != OP_STORE) |=> rsp_valid);
  a_r4_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
    !(acc && op != OP_STORE) |=> !rsp_valid);
  a_r2_head_hold: assert property (@(posedge clk) disable iff (rst)
    (!empty && !cw_ready) |=> $stable(cw_addr) && $stable(cw_data) && $stable(cw_be));
  a_r8_fence_ack: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_FENCE) |=> rsp_data == '0);
  a_r7_swap_full_word: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_SWAP) |-> (cw_valid && cw_be == {BE_W{1'b1}}));
endmodule

// File: tb/tso_store_buf_test.sv
`timescale 1ns/1ps
module tso_store_buf_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_valid, cw_valid, cr_en;
  logic [31:0] rsp_data, cw_addr, cw_data, cr_addr, cr_data;
  logic [3:0]  cw_be;
  logic        cw_ready = 1'b0;

  logic [31:0] mem  [16];
  logic [31:0] wlog [64];
  int          nlog = 0;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  tso_store_buf uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data), .cw_be(cw_be),
    .cw_ready(cw_ready), .cr_en(cr_en), .cr_addr(cr_addr), .cr_data(cr_data)
  );

  assign cr_data = mem[cr_addr[5:2]];

  always @(posedge clk) begin
    if (!rst && cw_valid && cw_ready) begin
      for (int b = 0; b < 4; b++)
        if (cw_be[b]) mem[cw_addr[5:2]][b*8 +: 8] <= cw_data[b*8 +: 8];
      wlog[nlog] <= cw_addr;
      nlog       <= nlog + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // {op, addr[7:0], data, be, expected load result}
  localparam logic [77:0] VEC [10] = '{
    {2'd0, 8'h04, 32'h0000_0000, 4'h0, 32'hC0DE_0001},
    {2'd1, 8'h04, 32'h1122_3344, 4'hF, 32'h0},
    {2'd0, 8'h04, 32'h0000_0000, 4'h0, 32'h1122_3344},
    {2'd1, 8'h08, 32'hAABB_CCDD, 4'h3, 32'h0},
    {2'd0, 8'h08, 32'h0000_0000, 4'h0, 32'hC0DE_CCDD},
    {2'd1, 8'h04, 32'h5566_7788, 4'h4, 32'h0},
    {2'd0, 8'h04, 32'h0000_0000, 4'h0, 32'h1166_3344},
    {2'd1, 8'h08, 32'h9900_0000, 4'h8, 32'h0},
    {2'd0, 8'h08, 32'h0000_0000, 4'h0, 32'h99DE_CCDD},
    {2'd0, 8'h0C, 32'h0000_0000, 4'h0, 32'hC0DE_0003}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int l0;
    for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 | i;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    req_op = 2'd1; #1;
    chk(req_ready === 1'b1, "R1 store ready after reset", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid low", {31'b0, rsp_valid}, 32'h0);
    chk(cw_valid === 1'b0, "R1 cw_valid low", {31'b0, cw_valid}, 32'h0);

    // table walk, cache writes held off: checks R4 R5 R6 R9
    for (int v = 0; v < 10; v++) begin
      issue(VEC[v][77:76], {24'h0, VEC[v][75:68]}, VEC[v][67:36], VEC[v][35:32]);
      if (VEC[v][77:76] == 2'd0) begin
        chk(rsp_valid === 1'b1, "R4 load response strobe", {31'b0, rsp_valid}, 32'h1);
        chk(rsp_data === VEC[v][31:0], "R5/R6 load data", rsp_data, VEC[v][31:0]);
      end else begin
        chk(rsp_valid === 1'b0, "R4 no response for store", {31'b0, rsp_valid}, 32'h0);
      end
    end

    // drain: R2 order and contents
    @(negedge clk); cw_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk(nlog == 4, "R2 write count", nlog, 4);
    chk(wlog[0] == 32'h04 && wlog[1] == 32'h08, "R2 order first pair", wlog[1], 32'h08);
    chk(wlog[2] == 32'h04 && wlog[3] == 32'h08, "R2 order second pair", wlog[3], 32'h08);
    chk(mem[1] == 32'h1166_3344, "R2 word 1 in cache", mem[1], 32'h1166_3344);
    chk(mem[2] == 32'h99DE_CCDD, "R2 word 2 in cache", mem[2], 32'h99DE_CCDD);

    // R3 full
    cw_ready = 1'b0;
    l0 = nlog;
    for (int k = 0; k < 8; k++) issue(2'd1, 32'h20 + 4*k, 32'h100 + k, 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 32'h0; req_be = 4'hF; #1;
    chk(req_ready === 1'b0, "R3 store blocked when full", {31'b0, req_ready}, 32'h0);
    req_op = 2'd0; req_addr = 32'h24; #1;
    chk(req_ready === 1'b1, "R9 load accepted when full", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b0;
    @(negedge clk); cw_ready = 1'b1;
    @(negedge clk); cw_ready = 1'b0;
    req_op = 2'd1; #1;
    chk(req_ready === 1'b1, "R3 room after one dequeue", {31'b0, req_ready}, 32'h1);
    chk(nlog == l0 + 1 && wlog[l0] == 32'h20, "R3 oldest written first", wlog[l0], 32'h20);

    // R10 stream while draining
    @(negedge clk); cw_ready = 1'b1;
    for (int k = 0; k < 4; k++) issue(2'd1, 32'h4 * k, 32'h200 + k, 4'hF);
    repeat (16) @(negedge clk);
    chk(nlog == l0 + 12, "R10 no store lost", nlog, l0 + 12);
    for (int k = 0; k < 12; k++) begin
      logic [31:0] e;
      e = (k < 8) ? 32'h20 + 4*k : 32'h4 * (k - 8);
      chk(wlog[l0 + k] == e, "R10 write order", wlog[l0 + k], e);
    end

    // R7 swap
    cw_ready = 1'b0;
    issue(2'd1, 32'h10, 32'hDEAD_BEEF, 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2; req_addr = 32'h10; req_wdata = 32'h1234_5678; #1;
    chk(req_ready === 1'b0, "R7 swap waits for drain", {31'b0, req_ready}, 32'h0);
    @(negedge clk); cw_ready = 1'b1; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_data === 32'hDEAD_BEEF, "R7 swap returns old word", rsp_data, 32'hDEAD_BEEF);
    @(negedge clk);
    chk(mem[4] === 32'h1234_5678, "R7 swap wrote new word", mem[4], 32'h1234_5678);

    // R8 fence
    cw_ready = 1'b0;
    issue(2'd1, 32'h14, 32'h0000_0001, 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; #1;
    chk(req_ready === 1'b0, "R8 fence stalls while queued", {31'b0, req_ready}, 32'h0);
    @(negedge clk); cw_ready = 1'b1; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_data === 32'h0, "R8 fence acknowledge", rsp_data, 32'h0);
    chk(mem[5] === 32'h0000_0001, "R8 drained before ack", mem[5], 32'h1);
    @(posedge clk); #1;
    chk(rsp_valid === 1'b0, "R4 single response pulse", {31'b0, rsp_valid}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule